// File: doc/BRIEF.md
# Indexed Video Control Register File

This block is the processor-facing register set of a small video controller. One byte-wide port is shared by index and data. A one-bit phase toggle decides what each write to that port means. In the index phase the byte selects a register. In the data phase the byte is written into the selected register. Reading the same port returns a status byte carrying the vertical-retrace input, and it also forces the toggle back to the index phase. Software therefore reads status once to bring the toggle into a known phase, then writes index and data pairs.

The stored registers are:
- a primary mode register;
- a palette mask;
- a border colour;
- a secondary mode register;
- sixteen 4-bit palette entries.

A separate port loads a colour-select byte directly, with no index. From the two mode registers the block decodes the display mode, a double-width flag and a blink-enable flag for the display pipeline.

The bus is a plain single-cycle byte strobe bus, and every access completes in the cycle it is presented. The block keeps no stream interface, so there is no valid/ready handshake and no back-pressure. Register contents and decoded flags are plain level outputs. Palette entries are read combinationally through a separate read-index input.

Top module: `vidreg_file`

## Requirements
- R1: After reset the toggle is in the index phase. Every register, every palette entry and the colour-select byte are 0. `disp_mode` is 0 (text), and `dbl_width` and `blink_en` are 0.
- R2: A write to port 0x3DA in the index phase stores the byte as the register index. A write in the data phase writes the byte into the indexed register. The phase flips after every accepted write to 0x3DA.
- R3: A read of port 0x3DA returns `vretrace_in` on bit 3 of `bus_rdata` and 0 on all other bits. The read returns the toggle to the index phase and changes no register. A read of any other port returns 0.
- R4: The data phase writes the full byte to one register, chosen by the index:
  - index 0 writes the primary mode register;
  - index 1 writes the palette mask;
  - index 2 writes the border colour;
  - index 3 writes the secondary mode register.
- R5: With indices 0x10 to 0x1F, the data phase stores the low 4 bits of the byte in palette entry (index − 0x10). `pal_rd_data` shows the entry selected by `pal_rd_idx`.
- R6: A data-phase write to any other index changes no register and no palette entry. The toggle still flips.
- R7: The display mode is decoded on `disp_mode` with the encoding 0 = text, 1 = 2-colour, 2 = 4-colour, 3 = 16-colour. The decode follows this priority:
  - primary bit 1 clear gives text;
  - otherwise, primary bit 4 set gives 16-colour;
  - otherwise, secondary bit 3 set gives 2-colour;
  - otherwise the mode is 4-colour.

  The outputs follow from the rising edge that accepts the data write.
- R8: `dbl_width` is 1 exactly when the mode is a graphics mode and bit 3 of the secondary register is 0.
- R9: `blink_en` equals bit 5 of the primary mode register.
- R10: A write to port 0x3D9 loads the colour-select byte and leaves the toggle unchanged. Writes to any other port have no effect.
- R11: If a read and a write to 0x3DA arrive in the same cycle, the read wins. The write is ignored and the toggle ends in the index phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Port address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| vretrace_in | input | 1 | Vertical-retrace status |
| pal_rd_idx | input | 4 | Palette read index |
| pal_rd_data | output | 4 | Selected palette entry |
| mode_ctl_o | output | 8 | Primary mode register |
| pal_mask_o | output | 8 | Palette mask register |
| border_o | output | 8 | Border colour register |
| ctl2_o | output | 8 | Secondary mode register |
| color_sel_o | output | 8 | Colour-select register |
| disp_mode | output | 2 | Decoded display mode |
| dbl_width | output | 1 | Double-width flag |
| blink_en | output | 1 | Blink-enable flag |

## Verification
The bench targets several corner cases, and each has a visible failure signature:
- **Status read mid-pair.** A status read lands between an index write and its data write. A design that did not clear the toggle would take the next index byte as data and corrupt the primary mode register.
- **Undefined indices.** Writes go to gaps in the index map. A design that dropped the toggle flip on them would mistake every later pair.
- **Decode priority.** The 16-colour bit and the 2-colour bit are set together. A wrong priority reports 2-colour.
- **Same-cycle read and write.** A design that let the write through would load a register and leave the toggle in the data phase.

Text mode with secondary bit 3 clear is also checked, since a decoder that ignored the graphics qualifier would raise double width there.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;
  typedef enum logic [1:0] {
    VM_TEXT  = 2'd0,
    VM_GFX2  = 2'd1,
    VM_GFX4  = 2'd2,
    VM_GFX16 = 2'd3
  } vmode_e;

  localparam logic [7:0] IDX_MODE   = 8'h00;
  localparam logic [7:0] IDX_MASK   = 8'h01;
  localparam logic [7:0] IDX_BORDER = 8'h02;
  localparam logic [7:0] IDX_CTL2   = 8'h03;

  typedef struct packed {
    logic [7:0] mode_ctl;
    logic [7:0] mask;
    logic [7:0] border;
    logic [7:0] ctl2;
  } ctl_regs_t;
endpackage

// File: rtl/vidreg_port_dec.sv
module vidreg_port_dec #(
  parameter int AW = 16,
  parameter logic [AW-1:0] DATA_PORT = 16'h03DA,
  parameter logic [AW-1:0] CSEL_PORT = 16'h03D9,
  parameter int RETRACE_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [7:0]    wdata,
  input  logic          vretrace,
  output logic [7:0]    rdata,
  output logic [7:0]    idx_q,
  output logic          reg_we,
  output logic          csel_we
);
  logic data_phase;
  logic hit_data, rd_hit, wr_hit;

  assign hit_data = (addr == DATA_PORT);
  assign rd_hit   = rd && hit_data;
  // a read on the shared port overrides a write in the same cycle
  assign wr_hit   = wr && hit_data && !rd_hit;
  assign reg_we   = wr_hit && data_phase;
  assign csel_we  = wr && (addr == CSEL_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_phase <= 1'b0;
      idx_q      <= 8'h00;
    end else if (rd_hit) begin
      data_phase <= 1'b0;
    end else if (wr_hit) begin
      if (!data_phase) idx_q <= wdata;
      data_phase <= ~data_phase;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_hit) rdata[RETRACE_BIT] = vretrace;
  end
endmodule

// File: rtl/vidreg_store.sv
module vidreg_store
  import vidreg_pkg::*;
#(
  parameter int PAL_N    = 16,
  parameter int PAL_W    = 4,
  parameter int PAL_BASE = 16,
  localparam int PIW     = $clog2(PAL_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       idx,
  input  logic [7:0]       wdata,
  input  logic             csel_we,
  input  logic [PIW-1:0]   pal_rd_idx,
  output ctl_regs_t        regs,
  output logic [7:0]       color_sel,
  output logic [PAL_W-1:0] pal_rd_data
);
  localparam logic [8:0] PAL_LO = 9'(PAL_BASE);
  localparam logic [8:0] PAL_HI = 9'(PAL_BASE + PAL_N);

  logic             pal_sel;
  logic [PIW-1:0]   pal_slot;
  logic [PAL_W-1:0] pal_q [PAL_N];

  assign pal_sel  = reg_we && ({1'b0, idx} >= PAL_LO) && ({1'b0, idx} < PAL_HI);
  assign pal_slot = PIW'(idx - PAL_LO[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (reg_we) begin
      case (idx)
        IDX_MODE:   regs.mode_ctl <= wdata;
        IDX_MASK:   regs.mask     <= wdata;
        IDX_BORDER: regs.border   <= wdata;
        IDX_CTL2:   regs.ctl2     <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       color_sel <= 8'h00;
    else if (csel_we) color_sel <= wdata;
  end

  for (genvar i = 0; i < PAL_N; i++) begin : g_pal
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pal_q[i] <= '0;
      else if (pal_sel && (pal_slot == PIW'(i)))
        pal_q[i] <= wdata[PAL_W-1:0];
    end
  end

  assign pal_rd_data = pal_q[pal_rd_idx];
endmodule

// File: rtl/vidreg_mode_dec.sv
module vidreg_mode_dec
  import vidreg_pkg::*;
(
  input  logic   gfx,
  input  logic   c16,
  input  logic   blink_bit,
  input  logic   c2,
  output vmode_e mode,
  output logic   dbl_width,
  output logic   blink_en
);
  always_comb begin
    if (!gfx)     mode = VM_TEXT;
    else if (c16) mode = VM_GFX16;
    else if (c2)  mode = VM_GFX2;
    else          mode = VM_GFX4;
  end

  assign dbl_width = gfx && !c2;
  assign blink_en  = blink_bit;
endmodule

// File: rtl/vidreg_file.sv
module vidreg_file
  import vidreg_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] DATA_PORT = 16'h03DA,
  parameter logic [AW-1:0] CSEL_PORT = 16'h03D9,
  parameter int RETRACE_BIT = 3,
  parameter int PAL_N    = 16,
  parameter int PAL_W    = 4,
  parameter int PAL_BASE = 16,
  parameter int GFX_BIT   = 1,
  parameter int C16_BIT   = 4,
  parameter int BLINK_BIT = 5,
  parameter int C2_BIT    = 3,
  localparam int PIW = $clog2(PAL_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             vretrace_in,
  input  logic [PIW-1:0]   pal_rd_idx,
  output logic [PAL_W-1:0] pal_rd_data,
  output logic [7:0]       mode_ctl_o,
  output logic [7:0]       pal_mask_o,
  output logic [7:0]       border_o,
  output logic [7:0]       ctl2_o,
  output logic [7:0]       color_sel_o,
  output logic [1:0]       disp_mode,
  output logic             dbl_width,
  output logic             blink_en
);
  logic [7:0] idx_q;
  logic       reg_we, csel_we;
  ctl_regs_t  regs;
  vmode_e     mode;

  vidreg_port_dec #(
    .AW(AW), .DATA_PORT(DATA_PORT), .CSEL_PORT(CSEL_PORT), .RETRACE_BIT(RETRACE_BIT)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .vretrace(vretrace_in), .rdata(bus_rdata),
    .idx_q(idx_q), .reg_we(reg_we), .csel_we(csel_we)
  );

  vidreg_store #(
    .PAL_N(PAL_N), .PAL_W(PAL_W), .PAL_BASE(PAL_BASE)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .idx(idx_q), .wdata(bus_wdata),
    .csel_we(csel_we), .pal_rd_idx(pal_rd_idx), .regs(regs),
    .color_sel(color_sel_o), .pal_rd_data(pal_rd_data)
  );

  vidreg_mode_dec u_mode (
    .gfx(regs.mode_ctl[GFX_BIT]), .c16(regs.mode_ctl[C16_BIT]),
    .blink_bit(regs.mode_ctl[BLINK_BIT]), .c2(regs.ctl2[C2_BIT]),
    .mode(mode), .dbl_width(dbl_width), .blink_en(blink_en)
  );

  assign disp_mode  = mode;
  assign mode_ctl_o = regs.mode_ctl;
  assign pal_mask_o = regs.mask;
  assign border_o   = regs.border;
  assign ctl2_o     = regs.ctl2;
endmodule

// File: rtl/vidreg_chk.sv
module vidreg_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] DATA_PORT = 16'h03DA,
  parameter logic [AW-1:0] CSEL_PORT = 16'h03D9,
  parameter int RETRACE_BIT = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic          vretrace_in,
  input logic [7:0]    mode_ctl_o,
  input logic [7:0]    pal_mask_o,
  input logic [7:0]    border_o,
  input logic [7:0]    ctl2_o,
  input logic [7:0]    color_sel_o,
  input logic [1:0]    disp_mode,
  input logic          dbl_width,
  input logic          blink_en
);
  a_r3_status_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == DATA_PORT) |-> (bus_rdata[RETRACE_BIT] == vretrace_in));

  a_r3_read_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> ($stable(mode_ctl_o) && $stable(pal_mask_o) && $stable(border_o) && $stable(ctl2_o)));

  a_r7_text: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ctl_o[1] |-> (disp_mode == 2'd0));

  a_r7_sixteen_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ctl_o[1] && mode_ctl_o[4]) |-> (disp_mode == 2'd3));

  a_r8_text_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_mode == 2'd0) |-> !dbl_width);

  a_r9_blink: assert property (@(posedge clk) disable iff (!rst_n)
    blink_en == mode_ctl_o[5]);

  a_r10_csel_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CSEL_PORT) |=> (color_sel_o == $past(bus_wdata)));

  a_r10_other_port: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != DATA_PORT && bus_addr != CSEL_PORT) |=>
      ($stable(mode_ctl_o) && $stable(border_o) && $stable(color_sel_o)));
endmodule

bind vidreg_file vidreg_chk #(
  .AW(AW), .DATA_PORT(DATA_PORT), .CSEL_PORT(CSEL_PORT), .RETRACE_BIT(RETRACE_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vretrace_in(vretrace_in),
  .mode_ctl_o(mode_ctl_o), .pal_mask_o(pal_mask_o), .border_o(border_o),
  .ctl2_o(ctl2_o), .color_sel_o(color_sel_o), .disp_mode(disp_mode),
  .dbl_width(dbl_width), .blink_en(blink_en)
);

// File: tb/vidreg_file_tb.sv
`timescale 1ns/1ps
module vidreg_file_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h0;
  logic [7:0]  bus_rdata;
  logic        vretrace_in = 1'b0;
  logic [3:0]  pal_rd_idx = 4'h0;
  logic [3:0]  pal_rd_data;
  logic [7:0]  mode_ctl_o, pal_mask_o, border_o, ctl2_o, color_sel_o;
  logic [1:0]  disp_mode;
  logic        dbl_width, blink_en;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [15:0] PD = 16'h03DA;
  localparam logic [15:0] PC = 16'h03D9;

  always #2.5 clk = ~clk;

  vidreg_file dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vretrace_in(vretrace_in),
    .pal_rd_idx(pal_rd_idx), .pal_rd_data(pal_rd_data), .mode_ctl_o(mode_ctl_o),
    .pal_mask_o(pal_mask_o), .border_o(border_o), .ctl2_o(ctl2_o),
    .color_sel_o(color_sel_o), .disp_mode(disp_mode), .dbl_width(dbl_width),
    .blink_en(blink_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic setreg(input logic [7:0] i, input logic [7:0] d);
    bwr(PD, i);
    bwr(PD, d);
  endtask

  task automatic t_reset();
    check("R1 mode_ctl", mode_ctl_o, 0);
    check("R1 border", border_o, 0);
    check("R1 color_sel", color_sel_o, 0);
    check("R1 disp_mode", disp_mode, 0);
    check("R1 dbl/blink", {dbl_width, blink_en}, 0);
    check("R1 palette 0", pal_rd_data, 0);
  endtask

  task automatic t_toggle();
    setreg(8'h00, 8'h12);
    check("R2 R4 mode_ctl", mode_ctl_o, 8'h12);
    setreg(8'h02, 8'hA5);
    check("R4 border", border_o, 8'hA5);
    setreg(8'h01, 8'h0F);
    check("R4 mask", pal_mask_o, 8'h0F);
    setreg(8'h03, 8'h08);
    check("R4 ctl2", ctl2_o, 8'h08);
    check("R2 mode_ctl untouched", mode_ctl_o, 8'h12);
  endtask

  task automatic t_mode();
    // mode_ctl 0x12 with ctl2 bit3 set: 16-colour wins over 2-colour
    check("R7 priority 16c", disp_mode, 3);
    check("R8 ctl2b3=1 narrow", dbl_width, 0);
    setreg(8'h00, 8'h02);
    check("R7 2-colour", disp_mode, 1);
    setreg(8'h03, 8'h00);
    check("R7 4-colour", disp_mode, 2);
    check("R8 4c wide", dbl_width, 1);
    setreg(8'h00, 8'h22);
    check("R9 blink on", blink_en, 1);
    setreg(8'h00, 8'h20);
    check("R7 text", disp_mode, 0);
    check("R8 text narrow", dbl_width, 0);
    setreg(8'h00, 8'h12);
    check("R7 16c", disp_mode, 3);
    check("R8 16c wide", dbl_width, 1);
    check("R9 blink off", blink_en, 0);
  endtask

  task automatic t_status();
    logic [7:0] v;
    vretrace_in = 1'b1;
    bwr(PD, 8'h00);
    brd(PD, v);
    check("R3 status retrace=1", v, 8'h08);
    vretrace_in = 1'b0;
    brd(PD, v);
    check("R3 status retrace=0", v, 8'h00);
    brd(PC, v);
    check("R3 other port reads 0", v, 8'h00);
    check("R3 read keeps mode_ctl", mode_ctl_o, 8'h12);
    setreg(8'h02, 8'h33);
    check("R3 toggle cleared: border", border_o, 8'h33);
    check("R3 toggle cleared: mode_ctl", mode_ctl_o, 8'h12);
  endtask

  task automatic t_palette();
    for (int i = 0; i < 16; i++) setreg(8'h10 + 8'(i), 8'hF0 | 8'(15 - i));
    for (int i = 0; i < 16; i++) begin
      pal_rd_idx = 4'(i);
      #1 check("R5 palette entry", pal_rd_data, 32'(15 - i));
    end
  endtask

  task automatic t_undef();
    setreg(8'h05, 8'hFF);
    setreg(8'h20, 8'hFF);
    setreg(8'h0F, 8'hFF);
    check("R6 mode_ctl kept", mode_ctl_o, 8'h12);
    check("R6 regs kept", {pal_mask_o, border_o, ctl2_o}, {8'h0F, 8'h33, 8'h00});
    pal_rd_idx = 4'd0;
    #1 check("R6 palette kept", pal_rd_data, 4'hF);
    setreg(8'h01, 8'h07);
    check("R6 toggle still flips", pal_mask_o, 8'h07);
  endtask

  task automatic t_csel();
    bwr(PC, 8'h3F);
    check("R10 color_sel", color_sel_o, 8'h3F);
    setreg(8'h02, 8'h44);
    check("R10 toggle untouched", border_o, 8'h44);
    bwr(16'h03D8, 8'hFF);
    check("R10 other port ignored", {mode_ctl_o, border_o, color_sel_o}, {8'h12, 8'h44, 8'h3F});
    setreg(8'h00, 8'h02);
    check("R10 toggle after stray", mode_ctl_o, 8'h02);
  endtask

  task automatic t_collide();
    bwr(PD, 8'h01);
    @(negedge clk);
    bus_addr = PD; bus_wdata = 8'h99; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R11 write ignored", pal_mask_o, 8'h07);
    setreg(8'h01, 8'h0C);
    check("R11 index phase after", pal_mask_o, 8'h0C);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_toggle();
    t_mode();
    t_status();
    t_palette();
    t_undef();
    t_csel();
    t_collide();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule